// File: doc/BRIEF.md
# Bit Test and Count Unit

This unit is a small registered integer datapath that answers one of four bit-level questions about its operands, picked by a two-bit opcode. It can check a 128-bit value against a 128-bit mask and report two flags. It can count the ones in a 32-bit word. It can count the zeros above the highest set bit of a 32-bit word. It can also return the position of that highest set bit.

A request is offered by raising `req_valid` with the opcode and operands on the same cycle. One clock later the unit raises `res_valid` for one cycle and presents a 32-bit result with a zero flag and a carry flag. The outputs keep their values until the next accepted request. This lets a consumer that reads late still see the last answer. It also gives a defined result for the highest-bit search on an all-zero word: the previous result is kept.

Top module: `bit_count_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `result`, `zf` and `cf` are all cleared to 0.
- R2: `res_valid` is high in exactly those cycles that follow a clock edge at which `req_valid` was high.
- R3: With opcode 0 (mask test), `zf` is 1 exactly when `opa AND opb` has no bit set.
- R4: With opcode 0, `cf` is 1 exactly when `(NOT opa) AND opb` has no bit set, which means every bit set in `opb` is also set in `opa`.
- R5: With opcode 0, `result` is 0.
- R6: With opcode 1 (population count), `result` is the number of ones in `cnt_in`, `zf` is 1 exactly when that count is 0, and `cf` is 0.
- R7: With opcode 2 (leading-zero count) and a nonzero `cnt_in`, `result` is 31 minus the index of the highest set bit, `zf` is 1 exactly when bit 31 is set, and `cf` is 0.
- R8: With opcode 2 and `cnt_in` equal to 0, `result` is 32, `cf` is 1 and `zf` is 0.
- R9: With opcode 3 (highest-bit index) and a nonzero `cnt_in`, `result` is the index (0 to 31) of the highest set bit, and `zf` and `cf` are both 0.
- R10: With opcode 3 and `cnt_in` equal to 0, `result` keeps its previous value, `zf` is 1 and `cf` is 0.
- R11: In a cycle that follows an edge with `req_valid` low, `result`, `zf` and `cf` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; operands sampled on this edge |
| req_op | input | 2 | Operation: 0 mask test, 1 ones count, 2 leading zeros, 3 highest-bit index |
| opa | input | 128 | Tested value for the mask test |
| opb | input | 128 | Mask for the mask test |
| cnt_in | input | 32 | Operand for the three counting operations |
| res_valid | output | 1 | One-cycle strobe marking a fresh result |
| result | output | 32 | Count or index; zero for the mask test |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |

## Verification
On every cycle, assertions check the timing of the strobe and that outputs hold between requests. They also check the zero-input outcomes of both the leading-zero count and the highest-bit search, the zeroed result of the mask test, and that the index found by the search points at a set bit. Only the bench scenarios can show that counts and indices are correct in value. The bench walks a single one through every bit position, and it sends all-zero, all-ones and random words. Only those scenarios can also show that the two mask-test flags agree with the full 128-bit logic for overlapping, disjoint, covering and partially covering masks.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

    parameter int unsigned WORD_W = 32;
    parameter int unsigned VEC_W  = 128;

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam int unsigned IDX_W = $clog2(WORD_W);

    typedef enum logic [1:0] {
        OP_MTEST  = 2'd0,
        OP_POPC   = 2'd1,
        OP_CLZ    = 2'd2,
        OP_MSBIDX = 2'd3
    } bit_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              zf;
        logic              cf;
    } bit_res_t;

    function automatic logic [WORD_W-1:0] widen_cnt(input logic [CNT_W-1:0] c);
        return {{(WORD_W-CNT_W){1'b0}}, c};
    endfunction

    function automatic logic [WORD_W-1:0] widen_idx(input logic [IDX_W-1:0] i);
        return {{(WORD_W-IDX_W){1'b0}}, i};
    endfunction

endpackage

// File: rtl/mask_tester.sv
module mask_tester #(
    parameter int unsigned W = 128
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] msk,
    output logic         none_hit,
    output logic         all_hit
);
    logic [W-1:0] hit_bits;
    logic [W-1:0] miss_bits;

    always_comb begin
        hit_bits  = val & msk;
        miss_bits = ~val & msk;
        none_hit  = (hit_bits == '0);
        all_hit   = (miss_bits == '0);
    end

    // R4
    always_comb begin
        flags_both_chk: assert ((none_hit && all_hit) == (msk == '0));
    end
endmodule

// File: rtl/pop_counter.sv
module pop_counter #(
    parameter int unsigned W   = 32,
    parameter int unsigned GRP = 8
) (
    input  logic [W-1:0]           vec,
    output logic [$clog2(W+1)-1:0] ones
);
    localparam int unsigned NGRP = W / GRP;
    localparam int unsigned GC_W = $clog2(GRP + 1);
    localparam int unsigned OC_W = $clog2(W + 1);

    logic [GC_W-1:0] grp_cnt [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb begin
            grp_cnt[g] = '0;
            for (int k = 0; k < GRP; k++) begin
                grp_cnt[g] = grp_cnt[g] + GC_W'(vec[g*GRP + k]);
            end
        end
    end

    always_comb begin
        ones = '0;
        for (int g = 0; g < NGRP; g++) begin
            ones = ones + OC_W'(grp_cnt[g]);
        end
    end
endmodule

// File: rtl/msb_locator.sv
module msb_locator #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] idx,
    output logic                 found
);
    localparam int unsigned IW = $clog2(W);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

    // R9
    always_comb begin
        msb_set_chk: assert (!found || vec[idx]);
    end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
    import bitcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [VEC_W-1:0]   opa,
    input  logic [VEC_W-1:0]   opb,
    input  logic [WORD_W-1:0]  cnt_in,
    output logic               res_valid,
    output logic [WORD_W-1:0]  result,
    output logic               zf,
    output logic               cf
);
    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_W  = CNT_W'(WORD_W);

    logic             t_none, t_all;
    logic [CNT_W-1:0] pop_cnt;
    logic [IDX_W-1:0] hi_idx;
    logic             hi_found;
    logic [CNT_W-1:0] lz_cnt;
    bit_op_e          op;
    bit_res_t         cur_q, nxt;
    logic             vld_q;

    mask_tester #(.W(VEC_W)) u_mask (
        .val(opa), .msk(opb), .none_hit(t_none), .all_hit(t_all)
    );

    pop_counter #(.W(WORD_W), .GRP(8)) u_pop (
        .vec(cnt_in), .ones(pop_cnt)
    );

    msb_locator #(.W(WORD_W)) u_msb (
        .vec(cnt_in), .idx(hi_idx), .found(hi_found)
    );

    always_comb begin
        op     = bit_op_e'(req_op);
        lz_cnt = hi_found ? (TOP_IDX - {1'b0, hi_idx}) : FULL_W;
        nxt    = cur_q;
        unique case (op)
            OP_MTEST: begin
                nxt.value = '0;
                nxt.zf    = t_none;
                nxt.cf    = t_all;
            end
            OP_POPC: begin
                nxt.value = widen_cnt(pop_cnt);
                nxt.zf    = (pop_cnt == '0);
                nxt.cf    = 1'b0;
            end
            OP_CLZ: begin
                nxt.value = widen_cnt(lz_cnt);
                nxt.zf    = (lz_cnt == '0);
                nxt.cf    = !hi_found;
            end
            OP_MSBIDX: begin
                if (hi_found) nxt.value = widen_idx(hi_idx);
                nxt.zf = !hi_found;
                nxt.cf = 1'b0;
            end
            default: nxt = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) cur_q <= nxt;
        end
    end

    assign res_valid = vld_q;
    assign result    = cur_q.value;
    assign zf        = cur_q.zf;
    assign cf        = cur_q.cf;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    // R5
    mtest_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd0) |=> (result == '0));
    // R6
    popc_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1) |=> (!cf && (zf == (result == '0))));
    // R8
    clz_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2 && cnt_in == '0)
            |=> (result == WORD_W'(WORD_W) && cf && !zf));
    // R10
    msb_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3 && cnt_in == '0)
            |=> ($stable(result) && zf && !cf));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(result) && $stable(zf) && $stable(cf)));
endmodule

// File: tb/sim_bit_count_unit.sv
`timescale 1ns/1ps
module sim_bit_count_unit;

    typedef struct packed {
        logic [31:0] r;
        logic        z;
        logic        c;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   req_op = 2'd0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [31:0]  cnt_in = '0;
    logic         res_valid;
    logic [31:0]  result;
    logic         zf, cf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] model_res = '0;

    always #2.5 clk = ~clk;

    bit_count_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .opa(opa), .opb(opb), .cnt_in(cnt_in),
        .res_valid(res_valid), .result(result), .zf(zf), .cf(cf)
    );

    function automatic int ref_ones(input logic [31:0] v);
        int n = 0;
        foreach (v[i]) if (v[i]) n++;
        return n;
    endfunction

    function automatic int ref_top(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input exp_t got, input exp_t want);
        n_tests++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got result=%0d zf=%0b cf=%0b, expected result=%0d zf=%0b cf=%0b",
                     tag, got.r, got.z, got.c, want.r, want.z, want.c);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [127:0] a,
                        input logic [127:0] b, input logic [31:0] c, input string tag);
        exp_t e;
        int   t;
        case (op)
            2'd0: begin
                e.r = '0; e.z = ((a & b) == '0); e.c = ((~a & b) == '0);
            end
            2'd1: begin
                e.r = 32'(ref_ones(c)); e.z = (e.r == 0); e.c = 1'b0;
            end
            2'd2: begin
                t = ref_top(c);
                e.r = (t < 0) ? 32'd32 : 32'(31 - t);
                e.z = (e.r == 0); e.c = (t < 0);
            end
            default: begin
                t = ref_top(c);
                e.r = (t < 0) ? model_res : 32'(t);
                e.z = (t < 0); e.c = 1'b0;
            end
        endcase
        model_res = e.r;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; opa = a; opb = b; cnt_in = c;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            opa = {4{$urandom}}; cnt_in = $urandom; req_op = 2'($urandom);
        end
    endtask

    // monitor: pops expected items as results appear
    initial begin
        exp_t last;
        bit   have = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (res_valid) begin
                    if (exp_q.size() == 0) begin
                        n_tests++; n_fail++;
                        $display("FAIL R2: res_valid=1 with no request pending, expected 0");
                    end else begin
                        last = exp_q.pop_front();
                        check(tag_q.pop_front(), {result, zf, cf}, last);
                        have = 1'b1;
                    end
                end else if (have) begin
                    check("R11 hold while idle", {result, zf, cf}, last);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] ra, rb;
        logic [31:0]  rc;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset state", {result, zf, cf}, '0);
        n_tests++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: res_valid=%0b, expected 0", res_valid);
        end
        rst = 1'b0;
        req_valid = 1'b0;
        idle(2);

        // mask test: R3 R4 R5
        send(2'd0, '0, '0, 32'h0, "R3 R4 R5 both zero");
        send(2'd0, '1, '1, 32'h0, "R3 R4 all ones covered");
        send(2'd0, 128'hF0, 128'h0F, 32'h0, "R3 R4 disjoint");
        send(2'd0, 128'hFF << 120, 128'h3C << 120, 32'h0, "R4 covering high bits");
        send(2'd0, 128'h1, 128'h3, 32'h0, "R3 R4 partial cover");
        idle(2);
        for (int i = 0; i < 12; i++) begin
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = (i % 3 == 0) ? (ra & {$urandom, $urandom, $urandom, $urandom}) :
                 (i % 3 == 1) ? (~ra & {$urandom, $urandom, $urandom, $urandom}) :
                                {$urandom, $urandom, $urandom, $urandom};
            send(2'd0, ra, rb, 32'h0, "R3 R4 random mask");
        end

        // population count: R6
        send(2'd1, '0, '0, 32'h0, "R6 zero word");
        send(2'd1, '0, '0, 32'hFFFF_FFFF, "R6 all ones");
        for (int i = 0; i < 32; i++) send(2'd1, '0, '0, 32'h1 << i, "R6 single bit");
        for (int i = 0; i < 10; i++) send(2'd1, '0, '0, $urandom, "R6 random");

        // leading zeros: R7 R8
        send(2'd2, '0, '0, 32'h0, "R8 zero word");
        send(2'd2, '0, '0, 32'hFFFF_FFFF, "R7 all ones");
        for (int i = 0; i < 32; i++) send(2'd2, '0, '0, 32'h1 << i, "R7 single bit");
        for (int i = 0; i < 10; i++) begin
            rc = $urandom >> (i * 3);
            send(2'd2, '0, '0, rc, "R7 R8 random");
        end
        idle(1);

        // highest-bit index: R9 R10
        send(2'd3, '0, '0, 32'h0000_0400, "R9 bit 10");
        send(2'd3, '0, '0, 32'h0, "R10 zero keeps result");
        idle(2);
        send(2'd3, '0, '0, 32'h0, "R10 zero again");
        send(2'd3, '0, '0, 32'hFFFF_FFFF, "R9 all ones");
        for (int i = 0; i < 32; i++) send(2'd3, '0, '0, 32'h1 << i, "R9 single bit");
        for (int i = 0; i < 10; i++) begin
            rc = $urandom >> (i * 3);
            send(2'd3, '0, '0, rc, "R9 R10 random");
        end
        send(2'd2, '0, '0, 32'h0, "R8 before zero search");
        send(2'd3, '0, '0, 32'h0, "R10 keeps leading-zero result");
        idle(4);

        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule